// File: doc/BRIEF.md
# Pipeline hazard stall scoreboard

This block sits beside the issue stage of a pipelined processor and decides, for every instruction presented to it, how many bubble cycles must be inserted before that instruction may proceed. It remembers which registers were written in recent issue slots and which registers were filled by a multi-register load. It also remembers whether a recent slot performed a jump or a memory write. Each remembered item is one bit of a 32-bit register mask per slot. General registers take bits 0 to 15. Special register k takes bit 16+k. The always-zero special registers at bits 16 and 20 are reused as the jump and memory-write markers.

For each accepted instruction the block evaluates every hazard rule against the history at issue time and adds the penalties. It reports the total one cycle later. It then holds `busy` high for that many cycles. Each of those cycles pushes an empty slot into the history, and the instruction's own mask enters the history after the last empty slot. Eight free-running counters accumulate the penalty cycles by cause. Instruction decode, the register file and the memory access itself lie outside the block.

The control is a two-state machine. READY accepts a strobe. On a strobe with a zero total it stays in READY (transition ACCEPT_CLEAN). On a strobe with a non-zero total it moves to STALL (transition ACCEPT_STALL). STALL counts the remaining bubbles and returns to READY after the last one (transition DRAIN_DONE). It stays in STALL otherwise (transition DRAIN_MORE).

Top module: `hz_scoreboard`

## Requirements
- R1: After synchronous reset, `stall_vld` and `busy` are 0 and every cause counter is 0. The history is empty, so the first instruction sees no hazard.
- R2: A strobe accepted in READY produces a one-cycle `stall_vld` pulse on the next cycle, with `stall_cnt` holding the total. `busy` is high for exactly `stall_cnt` cycles, starting in that same cycle. A strobe raised while `busy` is high is ignored: it gives no result and does not enter the history.
- R3: For each valid source operand (`src` or `opb`) that a multi-register load wrote 1, 2 or 3 slots earlier, the load-use penalty is 3, 2 or 1 cycles respectively. The larger of the two operands' values is used.
- R4: A memory read (class 1) is penalised 2 cycles when either of the two preceding slots holds the memory-write marker (bit 20). Memory writes are class 2.
- R5: A memory read or write whose address register (`src`) was written in the immediately preceding slot is penalised 1 cycle.
- R6: A jump through a register (class 4, register in `src`) is penalised 2 cycles if that register was written 1 slot earlier. It is penalised 1 cycle if the register was written 2 slots earlier.
- R7: A multiply (class 3) is penalised 1 cycle if either operand was written in the preceding slot. A multiply also marks special register 7 (bit 23) as written.
- R8: A jump sets the marker at bit 16. When the preceding slot carries that marker, a 16-bit immediate fetch (class 5) is penalised 1 cycle when `pc_hw` is 4'b1111, and a 32-bit immediate fetch (class 6) is penalised 1 cycle when `pc_hw` is 4'b1110.
- R9: A multi-register load (class 7) or store (class 8) of registers 0..`xfer_last` covers 4*(`xfer_last`+1) bytes from `xfer_base`. It is penalised 1 cycle per extra 32-byte line touched.
- R10: A multi-register store is penalised 2 cycles if any moved register was written 1 slot earlier. It is penalised 1 cycle if such a register was written 2 slots earlier.
- R11: Penalties from different causes add. Every bubble cycle inserts an empty history slot ahead of the instruction's own mask.
- R12: A register write aimed at index 16 or 20 does not set the jump or memory-write marker.
- R13: `cause_cnt` holds eight CNT_W-bit counters, from slot 0 upward: load-use, read-after-write, address register, multiply, jump register, jump target, line crossing, store source. Each counter grows by its cause's penalty on every accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_vld | input | 1 | Instruction strobe |
| op_class | input | 4 | Class: 0 exec, 1 mem read, 2 mem write, 3 multiply, 4 jump via register, 5 imm16, 6 imm32, 7 multi load, 8 multi store |
| src_idx | input | 5 | First source / address / jump register bit index |
| src_vld | input | 1 | First source valid |
| opb_idx | input | 5 | Second source register bit index |
| opb_vld | input | 1 | Second source valid |
| wr_idx | input | 5 | Written register bit index |
| wr_vld | input | 1 | Written register valid |
| pc_hw | input | LINE_LOG2-1 (4) | Half-word position of the instruction inside its 32-byte line |
| xfer_base | input | ADDR_W (32) | Start address of a multi-register transfer |
| xfer_last | input | XFER_W (4) | Highest register moved by a multi-register transfer |
| stall_vld | output | 1 | Result strobe, one cycle after acceptance |
| stall_cnt | output | 4 | Total bubble cycles for the accepted instruction |
| busy | output | 1 | High while bubbles are being inserted |
| cause_cnt | output | 8*CNT_W (128) | Per-cause penalty counters, cause 0 in the low bits |

## Verification
The properties assume that the issuer honours `busy`. They also assume that a per-instruction penalty never exceeds the three-cycle step that each counter property allows. The counter property also tolerates the counters wrapping. The bench waits for `busy` to fall before it offers the next instruction. It breaks that rule only once, on purpose, to show that a strobe during a stall is dropped. Between scenarios it flushes the history with three register-free instructions, so each expected total depends only on the slots the scenario creates.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int REG_W   = 32;
    localparam int IDX_W   = $clog2(REG_W);
    localparam int MOD_D   = 2;
    localparam int LD_D    = 3;
    localparam int PEN_W   = 2;
    localparam int STALL_W = 4;
    localparam int NCAUSE  = 8;

    localparam logic [IDX_W-1:0] JMP_MARK = IDX_W'(16);
    localparam logic [IDX_W-1:0] MWR_MARK = IDX_W'(20);
    localparam int               MOF_BIT  = 23;

    localparam int C_LOADUSE = 0;
    localparam int C_MEMRAW  = 1;
    localparam int C_ADDR    = 2;
    localparam int C_MUL     = 3;
    localparam int C_JSRC    = 4;
    localparam int C_JTGT    = 5;
    localparam int C_LINE    = 6;
    localparam int C_STSRC   = 7;

    typedef logic [REG_W-1:0] regmask_t;
    typedef logic [PEN_W-1:0] pen_t;

    typedef enum logic [3:0] {
        OP_EXEC  = 4'd0,
        OP_MEMRD = 4'd1,
        OP_MEMWR = 4'd2,
        OP_MUL   = 4'd3,
        OP_JMPR  = 4'd4,
        OP_IMM16 = 4'd5,
        OP_IMM32 = 4'd6,
        OP_LDM   = 4'd7,
        OP_STM   = 4'd8
    } op_class_e;

    typedef enum logic {
        ST_READY = 1'b0,
        ST_STALL = 1'b1
    } st_e;
endpackage

// File: rtl/hz_history.sv
module hz_history
    import hz_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     shift_en,
    input  regmask_t mod_in,
    input  regmask_t ld_in,
    output regmask_t mod_q [MOD_D],
    output regmask_t ld_q  [LD_D]
);
    for (genvar s = 0; s < MOD_D; s++) begin : g_mod
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)           mod_q[s] <= '0;
                else if (shift_en) mod_q[s] <= mod_in;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst)           mod_q[s] <= '0;
                else if (shift_en) mod_q[s] <= mod_q[s-1];
            end
        end
    end

    for (genvar s = 0; s < LD_D; s++) begin : g_ld
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)           ld_q[s] <= '0;
                else if (shift_en) ld_q[s] <= ld_in;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst)           ld_q[s] <= '0;
                else if (shift_en) ld_q[s] <= ld_q[s-1];
            end
        end
    end
endmodule

// File: rtl/hz_penalty.sv
module hz_penalty
    import hz_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LINE_LOG2 = 5,
    parameter int XFER_W    = 4
) (
    input  op_class_e                 cls,
    input  logic [IDX_W-1:0]          src_idx,
    input  logic                      src_vld,
    input  logic [IDX_W-1:0]          opb_idx,
    input  logic                      opb_vld,
    input  logic [LINE_LOG2-2:0]      pc_hw,
    input  logic [ADDR_W-1:0]         xfer_base,
    input  logic [XFER_W-1:0]         xfer_last,
    input  regmask_t                  mod_q [MOD_D],
    input  regmask_t                  ld_q  [LD_D],
    output logic [NCAUSE-1:0][PEN_W-1:0] pen,
    output regmask_t                  mv_mask
);
    localparam int LINE_W = ADDR_W - LINE_LOG2;

    pen_t              lu_s, lu_o;
    logic [ADDR_W-1:0] end_addr;
    logic [LINE_W-1:0] span;
    logic              is_xfer;

    always_comb begin
        for (int i = 0; i < REG_W; i++)
            mv_mask[i] = (i <= int'(xfer_last));
    end

    // load-use age scan: oldest first so the youngest hit wins
    always_comb begin
        lu_s = '0;
        lu_o = '0;
        for (int a = LD_D - 1; a >= 0; a--) begin
            if (src_vld && ld_q[a][src_idx]) lu_s = pen_t'(LD_D - a);
            if (opb_vld && ld_q[a][opb_idx]) lu_o = pen_t'(LD_D - a);
        end
    end

    always_comb begin
        end_addr = xfer_base + {{(ADDR_W-XFER_W-2){1'b0}}, xfer_last, 2'b11};
        span     = end_addr[ADDR_W-1:LINE_LOG2] - xfer_base[ADDR_W-1:LINE_LOG2];
        is_xfer  = (cls == OP_LDM) || (cls == OP_STM);
    end

    always_comb begin
        pen = '0;
        pen[C_LOADUSE] = (lu_s > lu_o) ? lu_s : lu_o;

        if (cls == OP_MEMRD && (mod_q[0][MWR_MARK] || mod_q[1][MWR_MARK]))
            pen[C_MEMRAW] = pen_t'(2);

        if ((cls == OP_MEMRD || cls == OP_MEMWR) && src_vld && mod_q[0][src_idx])
            pen[C_ADDR] = pen_t'(1);

        if (cls == OP_MUL && ((src_vld && mod_q[0][src_idx]) ||
                              (opb_vld && mod_q[0][opb_idx])))
            pen[C_MUL] = pen_t'(1);

        if (cls == OP_JMPR && src_vld) begin
            if (mod_q[0][src_idx])      pen[C_JSRC] = pen_t'(2);
            else if (mod_q[1][src_idx]) pen[C_JSRC] = pen_t'(1);
        end

        if (mod_q[0][JMP_MARK] &&
            ((cls == OP_IMM16 && pc_hw == '1) ||
             (cls == OP_IMM32 && pc_hw == ('1 - 1'b1))))
            pen[C_JTGT] = pen_t'(1);

        if (is_xfer)
            pen[C_LINE] = (|span[LINE_W-1:PEN_W]) ? '1 : span[PEN_W-1:0];

        if (cls == OP_STM) begin
            if ((mod_q[0] & mv_mask) != '0)      pen[C_STSRC] = pen_t'(2);
            else if ((mod_q[1] & mv_mask) != '0) pen[C_STSRC] = pen_t'(1);
        end
    end
endmodule

// File: rtl/hz_cause_ctr.sv
module hz_cause_ctr
    import hz_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         inc_en,
    input  logic [NCAUSE-1:0][PEN_W-1:0] pen,
    output logic [NCAUSE*CNT_W-1:0]      cnt_flat
);
    for (genvar c = 0; c < NCAUSE; c++) begin : g_ctr
        always_ff @(posedge clk) begin
            if (rst)
                cnt_flat[c*CNT_W +: CNT_W] <= '0;
            else if (inc_en)
                cnt_flat[c*CNT_W +: CNT_W] <= cnt_flat[c*CNT_W +: CNT_W] + CNT_W'(pen[c]);
        end
    end
endmodule

// File: rtl/hz_scoreboard.sv
module hz_scoreboard
    import hz_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LINE_LOG2 = 5,
    parameter int XFER_W    = 4,
    parameter int CNT_W     = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      issue_vld,
    input  logic [3:0]                op_class,
    input  logic [IDX_W-1:0]          src_idx,
    input  logic                      src_vld,
    input  logic [IDX_W-1:0]          opb_idx,
    input  logic                      opb_vld,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic                      wr_vld,
    input  logic [LINE_LOG2-2:0]      pc_hw,
    input  logic [ADDR_W-1:0]         xfer_base,
    input  logic [XFER_W-1:0]         xfer_last,
    output logic                      stall_vld,
    output logic [STALL_W-1:0]        stall_cnt,
    output logic                      busy,
    output logic [NCAUSE*CNT_W-1:0]   cause_cnt
);
    op_class_e                    cls;
    st_e                          state_q, state_d;
    logic [STALL_W-1:0]           rem_q, total;
    regmask_t                     held_mod_q, held_ld_q;
    regmask_t                     own_mod, own_ld, mv_mask;
    regmask_t                     mod_in, ld_in;
    regmask_t                     mod_q [MOD_D];
    regmask_t                     ld_q  [LD_D];
    logic [NCAUSE-1:0][PEN_W-1:0] pen;
    logic                         accept, shift_en;

    assign cls    = op_class_e'(op_class);
    assign accept = issue_vld && (state_q == ST_READY);
    assign busy   = (state_q == ST_STALL);

    hz_penalty #(.ADDR_W(ADDR_W), .LINE_LOG2(LINE_LOG2), .XFER_W(XFER_W)) i_pen (
        .cls(cls), .src_idx(src_idx), .src_vld(src_vld),
        .opb_idx(opb_idx), .opb_vld(opb_vld), .pc_hw(pc_hw),
        .xfer_base(xfer_base), .xfer_last(xfer_last),
        .mod_q(mod_q), .ld_q(ld_q), .pen(pen), .mv_mask(mv_mask)
    );

    always_comb begin
        total = '0;
        for (int c = 0; c < NCAUSE; c++)
            total = total + STALL_W'(pen[c]);
    end

    // mask this instruction leaves behind; marker slots are never set by a plain write
    always_comb begin
        own_mod = '0;
        if (wr_vld && wr_idx != JMP_MARK && wr_idx != MWR_MARK)
            own_mod[wr_idx] = 1'b1;
        case (cls)
            OP_MEMWR: own_mod[MWR_MARK] = 1'b1;
            OP_MUL:   own_mod[MOF_BIT]  = 1'b1;
            OP_JMPR:  own_mod[JMP_MARK] = 1'b1;
            OP_LDM:   own_mod = own_mod | mv_mask;
            default:  ;
        endcase
        own_ld = (cls == OP_LDM) ? mv_mask : '0;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: if (accept && total != '0) state_d = ST_STALL;
            ST_STALL: if (rem_q == '0)           state_d = ST_READY;
            default:  state_d = ST_READY;
        endcase
    end

    // history feed: bubbles push empty slots, own mask follows the last one
    always_comb begin
        shift_en = accept || busy;
        mod_in   = '0;
        ld_in    = '0;
        if (busy) begin
            if (rem_q == '0) begin
                mod_in = held_mod_q;
                ld_in  = held_ld_q;
            end
        end else if (total == '0) begin
            mod_in = own_mod;
            ld_in  = own_ld;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_READY;
            rem_q      <= '0;
            held_mod_q <= '0;
            held_ld_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                rem_q      <= total - 1'b1;
                held_mod_q <= own_mod;
                held_ld_q  <= own_ld;
            end else if (busy && rem_q != '0) begin
                rem_q <= rem_q - 1'b1;
            end
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            stall_vld <= 1'b0;
            stall_cnt <= '0;
        end else begin
            stall_vld <= accept;
            if (accept) stall_cnt <= total;
        end
    end

    hz_history i_hist (
        .clk(clk), .rst(rst), .shift_en(shift_en),
        .mod_in(mod_in), .ld_in(ld_in), .mod_q(mod_q), .ld_q(ld_q)
    );

    hz_cause_ctr #(.CNT_W(CNT_W)) i_ctr (
        .clk(clk), .rst(rst), .inc_en(accept), .pen(pen), .cnt_flat(cause_cnt)
    );
endmodule

// File: rtl/hz_scoreboard_chk.sv
module hz_scoreboard_chk
    import hz_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    issue_vld,
    input logic                    busy,
    input logic                    stall_vld,
    input logic [STALL_W-1:0]      stall_cnt,
    input logic [NCAUSE*CNT_W-1:0] cause_cnt
);
    logic [STALL_W-1:0] run_q, want_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            want_q <= '0;
        end else begin
            run_q <= busy ? run_q + 1'b1 : '0;
            if (stall_vld) want_q <= stall_cnt;
        end
    end

    p_result_follows_issue_r2: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && !busy) |=> stall_vld);

    p_no_result_without_accept_r2: assert property (@(posedge clk) disable iff (rst)
        !(issue_vld && !busy) |=> !stall_vld);

    p_busy_starts_with_result_r2: assert property (@(posedge clk) disable iff (rst)
        stall_vld |-> (busy == (stall_cnt != '0)));

    p_busy_length_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && run_q != '0) |-> (run_q == want_q));

    p_counters_hold_when_idle_r13: assert property (@(posedge clk) disable iff (rst)
        !(issue_vld && !busy) |=> $stable(cause_cnt));

    for (genvar c = 0; c < NCAUSE; c++) begin : g_step
        p_counter_step_r13: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (CNT_W'(cause_cnt[c*CNT_W +: CNT_W] - $past(cause_cnt[c*CNT_W +: CNT_W]))
                      <= CNT_W'(3)));
    end
endmodule

bind hz_scoreboard hz_scoreboard_chk #(.CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst(rst), .issue_vld(issue_vld), .busy(busy),
    .stall_vld(stall_vld), .stall_cnt(stall_cnt), .cause_cnt(cause_cnt)
);

// File: tb/test_hz_scoreboard.sv
module test_hz_scoreboard;
    import hz_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_vld = 1'b0;
    logic [3:0]  op_class = '0;
    logic [4:0]  src_idx = '0, opb_idx = '0, wr_idx = '0;
    logic        src_vld = 1'b0, opb_vld = 1'b0, wr_vld = 1'b0;
    logic [3:0]  pc_hw = '0;
    logic [31:0] xfer_base = '0;
    logic [3:0]  xfer_last = '0;
    logic        stall_vld, busy;
    logic [3:0]  stall_cnt;
    logic [127:0] cause_cnt;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_cnt [8];
    bit ghost = 1'b0;

    typedef struct { int val; string tag; } exp_t;
    exp_t exp_q [$];

    always #10 clk = ~clk;

    hz_scoreboard i_hz_scoreboard (
        .clk(clk), .rst(rst), .issue_vld(issue_vld), .op_class(op_class),
        .src_idx(src_idx), .src_vld(src_vld), .opb_idx(opb_idx), .opb_vld(opb_vld),
        .wr_idx(wr_idx), .wr_vld(wr_vld), .pc_hw(pc_hw), .xfer_base(xfer_base),
        .xfer_last(xfer_last), .stall_vld(stall_vld), .stall_cnt(stall_cnt),
        .busy(busy), .cause_cnt(cause_cnt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: pops one expected total per result strobe
    always @(negedge clk) begin
        if (!rst && stall_vld) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected result", int'(stall_cnt), -1);
            end else begin
                exp_t it;
                it = exp_q.pop_front();
                check(int'(stall_cnt) == it.val, it.tag, int'(stall_cnt), it.val);
            end
        end
    end

    // driver: called at a falling edge, returns at a falling edge with busy low
    task automatic op(input int cls, input int s, input int o, input int w,
                      input int pa, input int ca, input int pb, input int cb,
                      input string tag);
        exp_t it;
        int n = 0;
        op_class  = 4'(cls);
        src_vld   = (s >= 0);  src_idx = (s >= 0) ? 5'(s) : 5'd0;
        opb_vld   = (o >= 0);  opb_idx = (o >= 0) ? 5'(o) : 5'd0;
        wr_vld    = (w >= 0);  wr_idx  = (w >= 0) ? 5'(w) : 5'd0;
        issue_vld = 1'b1;
        it.val = pa + pb;
        it.tag = tag;
        exp_q.push_back(it);
        exp_cnt[ca] += pa;
        exp_cnt[cb] += pb;
        @(negedge clk);
        issue_vld = 1'b0;
        while (busy) begin
            n++;
            if (ghost && n == 1) begin
                op_class = 4'd0; wr_vld = 1'b1; wr_idx = 5'd7;
                src_vld = 1'b0; opb_vld = 1'b0;
                issue_vld = 1'b1;
            end else begin
                issue_vld = 1'b0;
            end
            @(negedge clk);
        end
        issue_vld = 1'b0;
        check(n == pa + pb, {"R2 busy length for ", tag}, n, pa + pb);
    endtask

    task automatic nop();
        op(0, -1, -1, -1, 0, 0, 0, 0, "R11 nop");
    endtask

    task automatic flush();
        for (int k = 0; k < 3; k++) nop();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < 8; c++) exp_cnt[c] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(stall_vld == 1'b0, "R1 stall_vld after reset", int'(stall_vld), 0);
        check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        check(cause_cnt == '0, "R1 counters after reset", int'(cause_cnt[31:0]), 0);
        op(1, 0, -1, -1, 0, 0, 0, 0, "R1 first read sees empty history");

        // R3 load-use by age
        flush(); xfer_base = 0; xfer_last = 3;
        op(7, 8, -1, -1, 0, 0, 0, 0, "R9 load in one line");
        op(0, 2, -1, -1, 3, C_LOADUSE, 0, 0, "R3 load-use age 1");
        flush(); op(7, 8, -1, -1, 0, 0, 0, 0, "R3 load"); nop();
        op(0, 1, -1, -1, 2, C_LOADUSE, 0, 0, "R3 load-use age 2");
        flush(); op(7, 8, -1, -1, 0, 0, 0, 0, "R3 load"); nop(); nop();
        op(0, -1, 3, -1, 1, C_LOADUSE, 0, 0, "R3 load-use age 3 via opb");
        flush(); op(7, 8, -1, -1, 0, 0, 0, 0, "R3 load"); nop(); nop(); nop();
        op(0, 0, -1, -1, 0, 0, 0, 0, "R3 load-use age 4 none");

        // R4 read after memory write
        flush(); op(2, 9, -1, -1, 0, 0, 0, 0, "R4 write");
        op(1, 10, -1, -1, 2, C_MEMRAW, 0, 0, "R4 read 1 slot after write");
        flush(); op(2, 9, -1, -1, 0, 0, 0, 0, "R4 write"); nop();
        op(1, 10, -1, -1, 2, C_MEMRAW, 0, 0, "R4 read 2 slots after write");
        flush(); op(2, 9, -1, -1, 0, 0, 0, 0, "R4 write"); nop(); nop();
        op(1, 10, -1, -1, 0, 0, 0, 0, "R4 read 3 slots after write");

        // R5 address register
        flush(); op(0, -1, -1, 6, 0, 0, 0, 0, "R5 write r6");
        op(1, 6, -1, -1, 1, C_ADDR, 0, 0, "R5 read addr age 1");
        flush(); op(0, -1, -1, 6, 0, 0, 0, 0, "R5 write r6");
        op(2, 6, -1, -1, 1, C_ADDR, 0, 0, "R5 write addr age 1");
        flush(); op(0, -1, -1, 6, 0, 0, 0, 0, "R5 write r6"); nop();
        op(1, 6, -1, -1, 0, 0, 0, 0, "R5 read addr age 2 none");

        // R6 jump through register
        flush(); op(0, -1, -1, 4, 0, 0, 0, 0, "R6 write r4");
        op(4, 4, -1, -1, 2, C_JSRC, 0, 0, "R6 jump age 1");
        flush(); op(0, -1, -1, 4, 0, 0, 0, 0, "R6 write r4"); nop();
        op(4, 4, -1, -1, 1, C_JSRC, 0, 0, "R6 jump age 2");
        flush(); op(0, -1, -1, 4, 0, 0, 0, 0, "R6 write r4"); nop(); nop();
        op(4, 4, -1, -1, 0, 0, 0, 0, "R6 jump age 3 none");

        // R7 multiply
        flush(); op(0, -1, -1, 2, 0, 0, 0, 0, "R7 write r2");
        op(3, 2, 3, 2, 1, C_MUL, 0, 0, "R7 multiply src hazard");
        flush(); op(0, -1, -1, 3, 0, 0, 0, 0, "R7 write r3");
        op(3, 1, 3, -1, 1, C_MUL, 0, 0, "R7 multiply opb hazard");
        flush(); op(3, 1, 1, 1, 0, 0, 0, 0, "R7 multiply clean");
        op(4, 23, -1, -1, 2, C_JSRC, 0, 0, "R7 multiply marks bit 23");

        // R8 immediates after a jump
        flush(); op(4, 0, -1, -1, 0, 0, 0, 0, "R8 jump");
        pc_hw = 4'hF; op(5, -1, -1, -1, 1, C_JTGT, 0, 0, "R8 imm16 at last half-word");
        flush(); op(4, 0, -1, -1, 0, 0, 0, 0, "R8 jump");
        pc_hw = 4'hE; op(5, -1, -1, -1, 0, 0, 0, 0, "R8 imm16 off boundary");
        flush(); op(4, 0, -1, -1, 0, 0, 0, 0, "R8 jump");
        pc_hw = 4'hE; op(6, -1, -1, -1, 1, C_JTGT, 0, 0, "R8 imm32 straddle");
        flush(); op(4, 0, -1, -1, 0, 0, 0, 0, "R8 jump");
        pc_hw = 4'hF; op(6, -1, -1, -1, 0, 0, 0, 0, "R8 imm32 off boundary");
        flush(); op(5, -1, -1, -1, 0, 0, 0, 0, "R8 imm16 without jump");
        pc_hw = 4'h0;

        // R9 line crossing
        flush(); xfer_base = 32'h10; xfer_last = 3;
        op(8, 9, -1, -1, 0, 0, 0, 0, "R9 store within line");
        flush(); xfer_base = 32'h18;
        op(8, 9, -1, -1, 1, C_LINE, 0, 0, "R9 store one extra line");
        flush(); xfer_base = 32'h1C; xfer_last = 15;
        op(7, 9, -1, -1, 2, C_LINE, 0, 0, "R9 load two extra lines");

        // R10 store source
        flush(); xfer_base = 0; xfer_last = 3;
        op(0, -1, -1, 2, 0, 0, 0, 0, "R10 write r2");
        op(8, 9, -1, -1, 2, C_STSRC, 0, 0, "R10 store age 1");
        flush(); op(0, -1, -1, 2, 0, 0, 0, 0, "R10 write r2"); nop();
        op(8, 9, -1, -1, 1, C_STSRC, 0, 0, "R10 store age 2");
        flush(); op(0, -1, -1, 5, 0, 0, 0, 0, "R10 write r5");
        op(8, 9, -1, -1, 0, 0, 0, 0, "R10 store outside range");

        // R11 sums and empty slots
        flush(); op(0, -1, -1, 2, 0, 0, 0, 0, "R11 write r2");
        xfer_base = 32'h18;
        op(8, 9, -1, -1, 2, C_STSRC, 1, C_LINE, "R11 store source plus line");
        flush(); xfer_base = 0;
        op(0, -1, -1, 5, 0, 0, 0, 0, "R11 write r5");
        op(1, 5, -1, -1, 1, C_ADDR, 0, 0, "R11 one bubble");
        op(4, 5, -1, -1, 0, 0, 0, 0, "R11 bubble pushed write out of range");
        flush(); op(7, -1, -1, -1, 0, 0, 0, 0, "R11 load");
        op(2, 9, -1, -1, 0, 0, 0, 0, "R11 write");
        op(1, 1, -1, -1, 2, C_LOADUSE, 2, C_MEMRAW, "R11 load-use plus raw");

        // R12 marker slots are not set by plain writes
        flush(); op(0, -1, -1, 16, 0, 0, 0, 0, "R12 write index 16");
        pc_hw = 4'hF; op(5, -1, -1, -1, 0, 0, 0, 0, "R12 no jump marker");
        pc_hw = 4'h0;
        flush(); op(0, -1, -1, 20, 0, 0, 0, 0, "R12 write index 20");
        op(1, 0, -1, -1, 0, 0, 0, 0, "R12 no write marker");

        // R2 strobe during a stall is dropped
        flush(); op(7, -1, -1, -1, 0, 0, 0, 0, "R2 load");
        ghost = 1'b1;
        op(0, 0, -1, -1, 3, C_LOADUSE, 0, 0, "R2 stall with ghost strobe");
        ghost = 1'b0;
        op(4, 7, -1, -1, 0, 0, 0, 0, "R2 ghost write absent");

        // R13 counters
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R2 all results seen", exp_q.size(), 0);
        for (int c = 0; c < 8; c++)
            check(int'(cause_cnt[c*16 +: 16]) == exp_cnt[c], "R13 cause counter",
                  int'(cause_cnt[c*16 +: 16]), exp_cnt[c]);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule